// File: doc/BRIEF.md
# Flash Page Copy-Back Sequencer

This block is the command side of a paged flash device with two page buffers, built as logic. A host shifts a 32-bit command into it over a serial link while chip select is held low. When chip select returns high and the command is a page rewrite, the block runs a timed operation. It first copies the addressed page of its internal array into one of the two buffers, then writes that buffer back into the same page. A ready output stays low for the whole timed window.

Three inputs (serial clock, chip select and data) are brought into the system clock domain through two-stage synchronisers, and each command bit is taken on a serial clock rising edge. Only one array operation may run at a time, so a rewrite that arrives while one is in flight is dropped. A write-protect input, when low, locks the lowest pages of the array against any rewrite. The array is a small page-wide memory whose contents are set at power-up and can be read out on a side port.

Top module: `flash_rewrite_seq`

## Requirements
- R1: After reset `ready` is 1 and both buffer outputs are 0. Page p of the array holds (p * 0x00010003) XOR 0xC3A50F00, truncated to 32 bits, and `peek_data` shows page `peek_page` one clock after it is presented.
- R2: A command is 32 bits sent most significant bit first and taken on each `spi_sck` rising edge while `spi_cs_n` is low. Bits 31..24 are the opcode, bits 18..9 are the page number, and bits 23..19 and 8..0 are ignored.
- R3: Opcode 0x58 rewrites through buffer 1 and opcode 0x59 rewrites through buffer 2. Any other opcode starts nothing: `ready` stays 1 and both buffers keep their values.
- R4: An operation starts only on a rising edge of `spi_cs_n` after a full 32 bits. A command cut short by an early chip-select rise is dropped, with no change to `ready` or the buffers.
- R5: The first phase copies the addressed page into the selected buffer, and the other buffer is left unchanged.
- R6: The second phase writes the selected buffer back into the same page, once, so every page still holds its power-up value after any number of rewrites.
- R7: `ready` falls within 6 clocks of the chip-select rise that starts an operation, and stays low for exactly BUSY_CYCLES clocks.
- R8: A rewrite whose chip-select rise comes while an operation is running is ignored. Both buffers keep their values and the running busy window is not lengthened.
- R9: With `wp_n` low, a rewrite of a page below PROT_PAGES (256) is refused: no busy window and no buffer change. With `wp_n` high, or for pages at or above PROT_PAGES, it runs.
- R10: A rewrite that completes around the cycle the running operation ends is either executed in full (full busy window and buffer loaded) or rejected in full, never in part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host, asynchronous |
| spi_cs_n | input | 1 | Active-low chip select, asynchronous |
| spi_mosi | input | 1 | Serial command data, asynchronous |
| wp_n | input | 1 | Active-low protect for the low pages |
| peek_page | input | PIDX_W (10) | Page to show on `peek_data` |
| peek_data | output | DATA_W (32) | Registered contents of page `peek_page` |
| ready | output | 1 | High when no array operation is running |
| buf1_data | output | DATA_W (32) | Contents of buffer 1 |
| buf2_data | output | DATA_W (32) | Contents of buffer 2 |

## Verification
The two functions that can coincide are the end of a running busy window and the arrival of a new rewrite. The bench starts an operation and then sends a second rewrite through buffer 2, delaying its start by a different number of clocks on each pass so that its chip-select rise sweeps across the cycle where the first window closes. Each pass is judged whole: either `ready` falls again for a full window and buffer 2 holds the new page, or `ready` stays high and buffer 2 is unchanged. Across the sweep both outcomes must appear.

// File: rtl/flash_rewrite_pkg.sv
package flash_rewrite_pkg;

  localparam int FRAME_BITS = 32;
  localparam int PAGE_FIELD_W = 10;

  localparam logic [7:0] OP_REWRITE_B1 = 8'h58;
  localparam logic [7:0] OP_REWRITE_B2 = 8'h59;

  typedef struct packed {
    logic [7:0]              opcode;
    logic [4:0]              rsvd;
    logic [PAGE_FIELD_W-1:0] page;
    logic [8:0]              pad;
  } cmd_frame_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_PROG,
    ST_HOLD
  } seq_state_t;

  // power-up contents of one page word
  function automatic logic [31:0] seed_word(input int unsigned idx);
    return (32'(idx) * 32'h0001_0003) ^ 32'hC3A5_0F00;
  endfunction

endpackage

// File: rtl/frw_sync.sv
module frw_sync #(
  parameter int              WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic stage1, stage2;
      always_ff @(posedge clk) begin
        if (rst) begin
          stage1 <= RST_VAL[g];
          stage2 <= RST_VAL[g];
        end else begin
          stage1 <= d[g];
          stage2 <= stage1;
        end
      end
      assign q[g] = stage2;
    end
  endgenerate

endmodule

// File: rtl/frw_frame_rx.sv
module frw_frame_rx #(
  parameter int FRAME_BITS = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sck_s,
  input  logic                  cs_n_s,
  input  logic                  mosi_s,
  output logic                  frame_vld,
  output logic [FRAME_BITS-1:0] frame
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

  logic                  sck_d;
  logic                  cs_d;
  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0]      bit_cnt;

  logic sck_rise, cs_rise, cs_fall;
  assign sck_rise = sck_s & ~sck_d;
  assign cs_rise  = cs_n_s & ~cs_d;
  assign cs_fall  = ~cs_n_s & cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d     <= 1'b0;
      cs_d      <= 1'b1;
      shreg     <= '0;
      bit_cnt   <= '0;
      frame_vld <= 1'b0;
      frame     <= '0;
    end else begin
      sck_d     <= sck_s;
      cs_d      <= cs_n_s;
      frame_vld <= 1'b0;
      if (cs_fall) begin
        bit_cnt <= '0;
      end else if (!cs_n_s && sck_rise && bit_cnt != FULL) begin
        shreg   <= {shreg[FRAME_BITS-2:0], mosi_s};
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (cs_rise && bit_cnt == FULL) begin
        frame_vld <= 1'b1;
        frame     <= shreg;
      end
    end
  end

endmodule

// File: rtl/frw_ctrl.sv
module frw_ctrl
  import flash_rewrite_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int PIDX_W      = 10,
  parameter int PROT_PAGES  = 256,
  parameter int BUSY_CYCLES = 200
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_vld,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  wp_n_s,
  output logic [PIDX_W-1:0]     mem_addr,
  output logic                  mem_we,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  ready,
  output logic [DATA_W-1:0]     buf1_q,
  output logic [DATA_W-1:0]     buf2_q
);

  localparam int CNT_W = $clog2(BUSY_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BUSY_CYCLES - 1);

  cmd_frame_t  cmd;
  seq_state_t  state;
  logic [CNT_W-1:0]  cnt;
  logic [PIDX_W-1:0] page_q;
  logic              sel_q;

  logic is_rewrite, locked, start;

  assign cmd        = cmd_frame_t'(frame);
  assign is_rewrite = (cmd.opcode == OP_REWRITE_B1) || (cmd.opcode == OP_REWRITE_B2);
  assign locked     = !wp_n_s && (32'(cmd.page) < PROT_PAGES);
  assign start      = frame_vld && is_rewrite && !locked && (state == ST_IDLE);

  assign mem_addr  = page_q;
  assign mem_we    = (state == ST_PROG);
  assign mem_wdata = sel_q ? buf2_q : buf1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      page_q <= '0;
      sel_q  <= 1'b0;
      ready  <= 1'b1;
      buf1_q <= '0;
      buf2_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_FETCH;
            cnt    <= '0;
            page_q <= cmd.page[PIDX_W-1:0];
            sel_q  <= (cmd.opcode == OP_REWRITE_B2);
            ready  <= 1'b0;
          end
        end
        ST_FETCH: begin
          state <= ST_LOAD;
          cnt   <= cnt + 1'b1;
        end
        ST_LOAD: begin
          if (sel_q) buf2_q <= mem_rdata;
          else       buf1_q <= mem_rdata;
          state <= ST_PROG;
          cnt   <= cnt + 1'b1;
        end
        ST_PROG: begin
          state <= ST_HOLD;
          cnt   <= cnt + 1'b1;
        end
        ST_HOLD: begin
          if (cnt == LAST) begin
            state <= ST_IDLE;
            ready <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/frw_page_mem.sv
module frw_page_mem
  import flash_rewrite_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PIDX_W = 10
) (
  input  logic              clk,
  input  logic [PIDX_W-1:0] a_addr,
  input  logic              a_we,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [PIDX_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_rdata
);

  localparam int DEPTH = 1 << PIDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'(seed_word(i));
  end

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/flash_rewrite_seq.sv
module flash_rewrite_seq
  import flash_rewrite_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int PIDX_W      = 10,
  parameter int PROT_PAGES  = 256,
  parameter int BUSY_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic              wp_n,
  input  logic [PIDX_W-1:0] peek_page,
  output logic [DATA_W-1:0] peek_data,
  output logic              ready,
  output logic [DATA_W-1:0] buf1_data,
  output logic [DATA_W-1:0] buf2_data
);

  logic [3:0] raw_in, sync_out;
  logic       sck_s, cs_n_s, mosi_s, wp_n_s;

  logic                  frame_vld;
  logic [FRAME_BITS-1:0] frame;

  logic [PIDX_W-1:0] mem_addr;
  logic              mem_we;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;

  assign raw_in = {wp_n, spi_mosi, spi_cs_n, spi_sck};
  assign {wp_n_s, mosi_s, cs_n_s, sck_s} = sync_out;

  frw_sync #(.WIDTH(4), .RST_VAL(4'b1010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_out)
  );

  frw_frame_rx #(.FRAME_BITS(FRAME_BITS)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .sck_s     (sck_s),
    .cs_n_s    (cs_n_s),
    .mosi_s    (mosi_s),
    .frame_vld (frame_vld),
    .frame     (frame)
  );

  frw_ctrl #(
    .DATA_W      (DATA_W),
    .PIDX_W      (PIDX_W),
    .PROT_PAGES  (PROT_PAGES),
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .frame_vld (frame_vld),
    .frame     (frame),
    .wp_n_s    (wp_n_s),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .ready     (ready),
    .buf1_q    (buf1_data),
    .buf2_q    (buf2_data)
  );

  frw_page_mem #(.DATA_W(DATA_W), .PIDX_W(PIDX_W)) u_mem (
    .clk     (clk),
    .a_addr  (mem_addr),
    .a_we    (mem_we),
    .a_wdata (mem_wdata),
    .a_rdata (mem_rdata),
    .b_addr  (peek_page),
    .b_rdata (peek_data)
  );

endmodule

// File: rtl/flash_rewrite_seq_chk.sv
module flash_rewrite_seq_chk #(
  parameter int BUSY_CYCLES = 200,
  parameter int DATA_W      = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mem_rdata
);

  localparam int LC_W = $clog2(BUSY_CYCLES + 2) + 1;

  logic [LC_W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst)        low_cnt <= '0;
    else if (ready) low_cnt <= '0;
    else            low_cnt <= low_cnt + 1'b1;
  end

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (low_cnt == LC_W'(BUSY_CYCLES))); // R7

  AST_BUSY_NO_GLITCH: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |=> !ready); // R7

  AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !ready); // R6

  AST_COPY_BACK: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == $past(mem_rdata))); // R6

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R6

endmodule

bind flash_rewrite_seq flash_rewrite_seq_chk #(
  .BUSY_CYCLES (BUSY_CYCLES),
  .DATA_W      (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ready     (ready),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata)
);

// File: tb/flash_rewrite_seq_bench.sv
module flash_rewrite_seq_bench;

  localparam int DATA_W = 32;
  localparam int PIDX_W = 10;
  localparam int PROT   = 256;
  localparam int BUSY   = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, wp_n = 1'b1;
  logic [PIDX_W-1:0] peek_page = '0;
  logic [DATA_W-1:0] peek_data, buf1_data, buf2_data;
  logic ready;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] b1_exp = '0, b2_exp = '0;

  always #5 clk = ~clk;

  flash_rewrite_seq #(
    .DATA_W(DATA_W), .PIDX_W(PIDX_W), .PROT_PAGES(PROT), .BUSY_CYCLES(BUSY)
  ) u_flash_rewrite_seq (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .wp_n(wp_n), .peek_page(peek_page),
    .peek_data(peek_data), .ready(ready),
    .buf1_data(buf1_data), .buf2_data(buf2_data)
  );

  function automatic logic [31:0] page_word(input int p);
    return (32'(p) * 32'h0001_0003) ^ 32'hC3A5_0F00;
  endfunction

  function automatic bit runs(input logic [7:0] op, input int page, input bit wp);
    return (op == 8'h58 || op == 8'h59) && !(!wp && page < PROT);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_frame(input logic [7:0] op, input int page, input int nbits);
    logic [31:0] f;
    f = {op, 5'($urandom), 10'(page), 9'($urandom)};
    spi_cs_n = 1'b0;
    tick(2);
    for (int i = 31; i >= 32 - nbits; i--) begin
      spi_mosi = f[i];
      tick(2);
      spi_sck = 1'b1;
      tick(2);
      spi_sck = 1'b0;
    end
    tick(2);
    spi_cs_n = 1'b1;
  endtask

  task automatic wait_fall(output bit fell);
    fell = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!ready) begin
        fell = 1'b1;
        break;
      end
    end
  endtask

  task automatic measure_low(output int n);
    n = 1;
    for (int i = 0; i < 4 * BUSY; i++) begin
      @(negedge clk);
      if (ready) break;
      n++;
    end
  endtask

  task automatic peek(input int p, output logic [31:0] d);
    @(negedge clk);
    peek_page = 10'(p);
    @(posedge clk);
    @(negedge clk);
    d = peek_data;
  endtask

  task automatic check_bufs(input string req);
    check({req, " buf1"}, buf1_data, b1_exp);
    check({req, " buf2"}, buf2_data, b2_exp);
  endtask

  task automatic do_op(input logic [7:0] op, input int page, input bit wp,
                       input int nbits, input string req);
    bit fell;
    bit exp_run;
    int n;
    logic [31:0] d;
    wp_n = wp;
    tick(4);
    send_frame(op, page, nbits);
    exp_run = (nbits == 32) && runs(op, page, wp);
    wait_fall(fell);
    check({req, " start"}, 32'(fell), 32'(exp_run));
    if (fell) begin
      measure_low(n);
      check("R7 busy length", n, BUSY);
    end
    tick(2);
    if (fell && op == 8'h58) b1_exp = page_word(page);
    if (fell && op == 8'h59) b2_exp = page_word(page);
    check_bufs(req);
    peek(page, d);
    check("R6 page kept", d, page_word(page));
  endtask

  initial begin
    logic [31:0] d;
    bit fell;
    int n1, n2, acc, rej;
    void'($urandom(32'd2024));
    tick(5);
    rst = 1'b0;
    tick(2);

    // R1 reset state and power-up contents
    check("R1 ready", 32'(ready), 32'd1);
    check_bufs("R1");
    peek(0, d);    check("R1 page0", d, page_word(0));
    peek(1023, d); check("R1 page1023", d, page_word(1023));

    // directed opcodes (R2 framing, R3 buffer choice, R5 copy)
    do_op(8'h58, 300, 1'b1, 32, "R5 op58");
    do_op(8'h59, 5,   1'b1, 32, "R3 op59");
    do_op(8'h57, 10,  1'b1, 32, "R3 other op");
    do_op(8'h59, 999, 1'b1, 32, "R2 high page");
    // R4 short frame dropped
    do_op(8'h58, 400, 1'b1, 20, "R4 short");
    // R9 protection boundaries
    do_op(8'h58, 255, 1'b0, 32, "R9 locked 255");
    do_op(8'h59, 256, 1'b0, 32, "R9 open 256");
    do_op(8'h58, 0,   1'b1, 32, "R9 wp high 0");

    // R8 rewrite during busy is ignored
    wp_n = 1'b1;
    tick(4);
    send_frame(8'h58, 700, 32);
    wait_fall(fell);
    check("R8 first start", 32'(fell), 32'd1);
    fork
      measure_low(n1);
      begin tick(2); send_frame(8'h59, 800, 32); end
    join
    check("R8 window not extended", n1, BUSY);
    wait_fall(fell);
    check("R8 no late start", 32'(fell), 32'd0);
    b1_exp = page_word(700);
    check_bufs("R8");

    // R10 sweep the second command across the end of the window
    acc = 0;
    rej = 0;
    for (int w = 40; w <= 92; w += 2) begin
      tick(4);
      send_frame(8'h58, 256 + w, 32);
      wait_fall(fell);
      check("R10 first start", 32'(fell), 32'd1);
      fork
        measure_low(n1);
        begin tick(w); send_frame(8'h59, 600 + w, 32); end
      join
      check("R10 first length", n1, BUSY);
      wait_fall(fell);
      if (fell) begin
        acc++;
        measure_low(n2);
        check("R10 second length", n2, BUSY);
        b2_exp = page_word(600 + w);
      end else begin
        rej++;
      end
      tick(2);
      b1_exp = page_word(256 + w);
      check_bufs("R10");
    end
    check("R10 some accepted", 32'(acc > 0), 32'd1);
    check("R10 some rejected", 32'(rej > 0), 32'd1);

    // constrained random mix
    for (int k = 0; k < 30; k++) begin
      logic [7:0] op;
      int sel;
      sel = int'($urandom % 4);
      op  = (sel == 0) ? 8'h58 : (sel == 1) ? 8'h59 : (sel == 2) ? 8'h57 : 8'($urandom);
      do_op(op, int'($urandom % 1024), 1'($urandom), 32, "R3 random");
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule